// File: doc/BRIEF.md
# Power-Up Strap Latch Sequencer

This block turns a group of dual-purpose pads into configuration inputs for a short time after power-up, and then into clock outputs. A power-good signal marks the point where the supply has crossed its threshold. While power-good is low, every pad is three-stated. Once power-good is high, a window timer counts cycles of the free-running reference clock. At the end of the window the level on each pad is captured. The pad drivers are then enabled, but they are forced low for one cycle so the new settings can settle. After that cycle the clocks are allowed through.

The captured bits are four frequency-select straps and one mode strap. They are kept until power-good falls again. Neither later pad activity nor changes to the software select inputs can alter them. The block also combines the captured bits with the software select fields to produce three results:
- the effective frequency code,
- the PCI divide ratio that goes with that code,
- the function of the shared reference/stop pin.

Top module: `strap_latch_seq`

## Requirements
- R1: While `pwr_good` is low, `pad_oe` is all zeros and `pad_force_low` is 0. `strap_fs` and `strap_mode` are cleared to 0 asynchronously.
- R2: After `pwr_good` goes high, `pad_oe` stays all zeros through the first WINDOW_CYCLES-1 rising edges of `clk_ref`. It becomes all ones right after rising edge number WINDOW_CYCLES.
- R3: The pad levels present at rising edge number WINDOW_CYCLES are captured, and levels earlier in the window have no effect. Pad bit 0..3 maps to `strap_fs[0..3]`, and pad bit 4 maps to `strap_mode`.
- R4: `pad_force_low` is 1 for exactly the first clock cycle in which `pad_oe` is high, and 0 from then on.
- R5: Once captured, `strap_fs` and `strap_mode` keep their values until `pwr_good` falls. Changes on `pad_in`, `sw_sel_en` or `sw_sel` do not alter them.
- R6: `freq_sel` follows `strap_fs` when `sw_sel_en` is 0, and follows `sw_sel` when `sw_sel_en` is 1.
- R7: `pci_div3` is 0 (PCI clock = CPU/2) for `freq_sel` codes 4'b1111, 4'b1110, 4'b1101, 4'b0111 and 4'b0101. It is 1 (CPU/3) for every other code.
- R8: `pin2_stop_sel` is 1 (the pin acts as the PCI stop input) when `strap_mode` is 0. It is 0 (the pin drives the reference clock) when `strap_mode` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| pwr_good | input | 1 | Supply above threshold; low acts as asynchronous power reset |
| pad_in | input | 5 | Pad input levels; bits 3:0 are the frequency straps, bit 4 is the mode strap |
| sw_sel_en | input | 1 | 1 selects the software frequency code |
| sw_sel | input | 4 | Software frequency code from the configuration registers |
| pad_oe | output | 5 | Per-pad output enable |
| pad_force_low | output | 1 | Enabled pads drive logic 0 |
| strap_fs | output | 4 | Captured frequency straps |
| strap_mode | output | 1 | Captured mode strap |
| freq_sel | output | 4 | Effective frequency select code |
| pci_div3 | output | 1 | 1 = PCI at CPU/3, 0 = PCI at CPU/2 |
| pin2_stop_sel | output | 1 | 1 = shared pin is the PCI stop input |

## Verification
The hardest case to create is a strap level that changes inside the window and only settles on the final counted edge. Showing that the early level is ignored means placing a pad change exactly one cycle before the end of the window. The stimulus therefore drives the opposite pattern during most of the window and switches to the intended pattern on the falling edge before the capture edge. It then checks the captured bits and the output-enable timing around that edge. A second hard case is showing that the captured bits survive later activity: the bench toggles every pad and the software select inputs after capture, and only a fall of `pwr_good` clears the straps.

// File: rtl/strap_latch_seq.sv
module strap_latch_seq #(
  parameter int WINDOW_CYCLES = 28637,
  parameter int SEL_W         = 4
) (
  input  logic                clk_ref,
  input  logic                pwr_good,
  input  logic [SEL_W:0]      pad_in,
  input  logic                sw_sel_en,
  input  logic [SEL_W-1:0]    sw_sel,
  output logic [SEL_W:0]      pad_oe,
  output logic                pad_force_low,
  output logic [SEL_W-1:0]    strap_fs,
  output logic                strap_mode,
  output logic [SEL_W-1:0]    freq_sel,
  output logic                pci_div3,
  output logic                pin2_stop_sel
);

  localparam int NUM_PADS = SEL_W + 1;
  localparam int CNT_W    = $clog2(WINDOW_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_CYCLES - 1);

  typedef enum logic [1:0] {PH_WIN, PH_HOLD, PH_RUN} phase_t;

  phase_t            phase;
  logic [CNT_W-1:0]  win_cnt;
  logic [SEL_W:0]    cap_q;
  logic              win_end;

  assign win_end = (phase == PH_WIN) && (win_cnt == LAST);

  always_ff @(posedge clk_ref or negedge pwr_good) begin
    if (!pwr_good) begin
      phase   <= PH_WIN;
      win_cnt <= '0;
    end else begin
      unique case (phase)
        PH_WIN:  if (win_end) phase <= PH_HOLD;
                 else win_cnt <= win_cnt + 1'b1;
        PH_HOLD: phase <= PH_RUN;
        default: phase <= PH_RUN;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_PADS; i++) begin : g_cap
    always_ff @(posedge clk_ref or negedge pwr_good) begin
      if (!pwr_good)   cap_q[i] <= 1'b0;
      else if (win_end) cap_q[i] <= pad_in[i];
    end
  end

  assign pad_oe        = {NUM_PADS{phase != PH_WIN}};
  assign pad_force_low = (phase == PH_HOLD);
  assign strap_fs      = cap_q[SEL_W-1:0];
  assign strap_mode    = cap_q[SEL_W];
  assign pin2_stop_sel = ~cap_q[SEL_W];
  assign freq_sel      = sw_sel_en ? sw_sel : cap_q[SEL_W-1:0];

  always_comb begin
    unique case (freq_sel[3:0])
      4'b1111, 4'b1110, 4'b1101, 4'b0111, 4'b0101: pci_div3 = 1'b0;
      default:                                     pci_div3 = 1'b1;
    endcase
  end

endmodule

module strap_latch_seq_chk #(
  parameter int WINDOW_CYCLES = 28637,
  parameter int SEL_W         = 4
) (
  input logic             clk_ref,
  input logic             pwr_good,
  input logic [SEL_W:0]   pad_oe,
  input logic             pad_force_low,
  input logic [SEL_W-1:0] strap_fs,
  input logic             strap_mode
);
  localparam int CW = $clog2(WINDOW_CYCLES + 2) + 1;
  logic [CW-1:0] seen;

  always_ff @(posedge clk_ref or negedge pwr_good) begin
    if (!pwr_good) seen <= '0;
    else if (seen <= CW'(WINDOW_CYCLES)) seen <= seen + 1'b1;
  end

  p_window_len_r2: assert property (@(posedge clk_ref) disable iff (!pwr_good)
    $rose(pad_oe[0]) |-> seen == CW'(WINDOW_CYCLES));

  p_oe_sticky_r2: assert property (@(posedge clk_ref) disable iff (!pwr_good)
    pad_oe[0] |=> pad_oe[0]);

  p_low_first_r4: assert property (@(posedge clk_ref) disable iff (!pwr_good)
    $rose(pad_oe[0]) |-> pad_force_low);

  p_low_once_r4: assert property (@(posedge clk_ref) disable iff (!pwr_good)
    pad_force_low |=> !pad_force_low);

  p_strap_hold_r5: assert property (@(posedge clk_ref) disable iff (!pwr_good)
    (pad_oe[0] && $past(pad_oe[0])) |-> ($stable(strap_fs) && $stable(strap_mode)));
endmodule

bind strap_latch_seq strap_latch_seq_chk #(
  .WINDOW_CYCLES(WINDOW_CYCLES), .SEL_W(SEL_W)
) u_chk (
  .clk_ref(clk_ref), .pwr_good(pwr_good), .pad_oe(pad_oe),
  .pad_force_low(pad_force_low), .strap_fs(strap_fs), .strap_mode(strap_mode)
);

// File: tb/strap_latch_seq_tb.sv
`timescale 1ns/1ps
module strap_latch_seq_tb;
  localparam int W = 20;

  logic       clk_ref = 1'b0;
  logic       pwr_good = 1'b0;
  logic [4:0] pad_in = '0;
  logic       sw_sel_en = 1'b0;
  logic [3:0] sw_sel = '0;
  logic [4:0] pad_oe;
  logic       pad_force_low;
  logic [3:0] strap_fs;
  logic       strap_mode;
  logic [3:0] freq_sel;
  logic       pci_div3;
  logic       pin2_stop_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk_ref = ~clk_ref;

  strap_latch_seq #(.WINDOW_CYCLES(W), .SEL_W(4)) u_dut (
    .clk_ref(clk_ref), .pwr_good(pwr_good), .pad_in(pad_in),
    .sw_sel_en(sw_sel_en), .sw_sel(sw_sel), .pad_oe(pad_oe),
    .pad_force_low(pad_force_low), .strap_fs(strap_fs), .strap_mode(strap_mode),
    .freq_sel(freq_sel), .pci_div3(pci_div3), .pin2_stop_sel(pin2_stop_sel)
  );

  // {pads[4:0], sw_en, sw_sel[3:0], exp_freq[3:0], exp_div3, exp_stop}
  localparam logic [15:0] VEC [8] = '{
    {5'b11111, 1'b0, 4'b0000, 4'b1111, 1'b0, 1'b0},
    {5'b00101, 1'b0, 4'b1111, 4'b0101, 1'b0, 1'b1},
    {5'b10110, 1'b0, 4'b0000, 4'b0110, 1'b1, 1'b0},
    {5'b00000, 1'b1, 4'b1101, 4'b1101, 1'b0, 1'b1},
    {5'b11010, 1'b1, 4'b0111, 4'b0111, 1'b0, 1'b0},
    {5'b01100, 1'b0, 4'b0101, 4'b1100, 1'b1, 1'b1},
    {5'b11110, 1'b1, 4'b0011, 4'b0011, 1'b1, 1'b0},
    {5'b01110, 1'b0, 4'b0000, 4'b1110, 1'b0, 1'b1}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic power_cycle();
    @(negedge clk_ref) pwr_good = 1'b0;
    @(negedge clk_ref) pwr_good = 1'b1;
  endtask

  initial begin
    // R1: reset state
    #3;
    check("R1 oe", 8'(pad_oe), 8'h00);
    check("R1 force_low", 8'(pad_force_low), 8'h00);
    check("R1 straps", 8'({strap_mode, strap_fs}), 8'h00);

    // table walk: R3, R6, R7, R8
    foreach (VEC[k]) begin
      pad_in = VEC[k][15:11];
      sw_sel_en = VEC[k][10];
      sw_sel = VEC[k][9:6];
      power_cycle();
      repeat (W + 1) @(posedge clk_ref);
      #1;
      check("R3 strap capture", 8'({strap_mode, strap_fs}), 8'(VEC[k][15:11]));
      check("R6 freq_sel", 8'(freq_sel), 8'(VEC[k][5:2]));
      check("R7 pci_div3", 8'(pci_div3), 8'(VEC[k][1]));
      check("R8 pin2_stop_sel", 8'(pin2_stop_sel), 8'(VEC[k][0]));
    end

    // R2/R3/R4: late pad change and enable timing
    sw_sel_en = 1'b0;
    pad_in = 5'b01010;
    power_cycle();
    check("R1 straps cleared", 8'({strap_mode, strap_fs}), 8'h00);
    repeat (W - 1) @(posedge clk_ref);
    #1;
    check("R2 oe still off", 8'(pad_oe), 8'h00);
    @(negedge clk_ref) pad_in = 5'b10101;
    @(posedge clk_ref);
    #1;
    check("R2 oe on", 8'(pad_oe), 8'h1f);
    check("R4 force_low first", 8'(pad_force_low), 8'h01);
    check("R3 last level", 8'({strap_mode, strap_fs}), 8'h15);
    @(posedge clk_ref);
    #1;
    check("R4 force_low released", 8'(pad_force_low), 8'h00);
    check("R2 oe kept", 8'(pad_oe), 8'h1f);

    // R5: later activity ignored
    @(negedge clk_ref) begin pad_in = 5'b01010; sw_sel = 4'b1111; end
    repeat (3) @(posedge clk_ref);
    #1;
    check("R5 pads ignored", 8'({strap_mode, strap_fs}), 8'h15);
    check("R6 sw ignored when off", 8'(freq_sel), 8'h05);
    @(negedge clk_ref) sw_sel_en = 1'b1;
    #1;
    check("R6 sw selected", 8'(freq_sel), 8'h0f);
    check("R7 div2 for 1111", 8'(pci_div3), 8'h00);
    check("R5 sw write ignored", 8'({strap_mode, strap_fs}), 8'h15);

    // R1: power loss clears
    @(negedge clk_ref) pwr_good = 1'b0;
    #1;
    check("R1 cleared", 8'({strap_mode, strap_fs}), 8'h00);
    check("R1 oe off", 8'(pad_oe), 8'h00);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_ref);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule